// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small stored-program processor with a single accumulator. Code and data share one memory of 4096 sixteen-bit words, which sits behind one port. The port carries a 12-bit word address, a read bus, a write bus and a write strobe. The core drives the address, the write data and the strobe from its registers. The memory samples them on the falling clock edge and returns read data on that same falling edge. The core's own registers all update on the rising edge.

Every instruction takes exactly two clock cycles. In the first cycle the core fetches the word at the program counter and increments the counter. In the second cycle it executes that word. The top four bits of the word select the operation and the low twelve bits give a memory address. A single arithmetic unit computes the counter increment, the accumulator arithmetic and the jump targets. The STOP operation freezes the core and raises `halted` until reset.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the first cycle after it falls, `mem_addr` is 0, `mem_we` is 0 and `halted` is 0. The first instruction is fetched from address 0.
- R2: Cycles alternate between fetch and execute. In a fetch cycle `mem_addr` equals the program counter. In the following execute cycle `mem_addr` equals bits [11:0] of the fetched word, for every opcode. Without a taken jump, the next fetch address is the previous one plus one.
- R3: Opcode 0 (bits [15:12]) loads the accumulator from the operand address. Opcode 1 holds `mem_we` high for exactly its execute cycle, with `mem_wdata` equal to the accumulator and `mem_addr` equal to the operand.
- R4: Opcode 2 adds the word at the operand address to the accumulator, modulo 2^16.
- R5: Opcode 3 subtracts the word at the operand address from the accumulator, modulo 2^16.
- R6: Opcode 4 makes the next fetch come from the operand address.
- R7: Opcode 5 jumps to the operand address only when accumulator bit 15 is 0. Otherwise execution continues in sequence.
- R8: Opcode 6 jumps to the operand address only when the accumulator is nonzero. Otherwise execution continues in sequence.
- R9: Opcode 7 stops the core. From the cycle after its execute cycle until reset, `halted` is 1, `mem_we` is 0 and `mem_addr` holds the STOP word's address plus one.
- R10: Opcodes 8 through 15 change neither the accumulator nor memory. The next fetch is sequential.
- R11: Sequential fetch from address 0xFFF continues at address 0x000.
- R12: The program 0004, 2005, 1006, 7000 placed at address 0, with 000A at address 4 and 0001 at address 5, leaves 000B at address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address to memory |
| mem_rdata | input | 16 | Word read by memory on the falling edge |
| mem_wdata | output | 16 | Accumulator value offered for writing |
| mem_we | output | 1 | Write strobe; memory stores on the falling edge |
| halted | output | 1 | High once STOP has executed, until reset |

## Verification
The fetch address is due in the cycle right after the release of reset, and again every second cycle after that. The operand address and any store data are due one cycle after each fetch. The `halted` flag is due in the cycle after STOP executes. A reference interpreter in the bench turns each program into one expected bus item per cycle. A monitor pops one item every cycle, 1 ns after the falling edge, when memory has already acted on the bus and the core's rising-edge outputs are settled. An accumulator result is due only on the rising edge that leaves execute, so it is observed through a later store and the final memory contents.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int unsigned OPC_W = 4;
  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OPC_LOAD  = 4'd0;
  localparam opc_t OPC_STORE = 4'd1;
  localparam opc_t OPC_ADD   = 4'd2;
  localparam opc_t OPC_SUB   = 4'd3;
  localparam opc_t OPC_JUMP  = 4'd4;
  localparam opc_t OPC_JPOS  = 4'd5;
  localparam opc_t OPC_JNZ   = 4'd6;
  localparam opc_t OPC_STOP  = 4'd7;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_HALT  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ALU_INC  = 2'd0,
    ALU_PASS = 2'd1,
    ALU_ADD  = 2'd2,
    ALU_SUB  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    pc_en;
    logic    ir_en;
    logic    acc_en;
    logic    addr_from_ir;
    logic    x_from_acc;
    logic    y_from_ir;
    alu_op_e alu_op;
    logic    mem_we;
  } ctl_t;

endpackage

// File: rtl/acc_enreg.sv
module acc_enreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  x,
  input  logic [DW-1:0]  y,
  output logic [DW-1:0]  res
);

  function automatic logic [DW-1:0] alu_eval(input alu_op_e f,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW-1:0] r;
    unique case (f)
      ALU_INC:  r = a + DW'(1);
      ALU_PASS: r = b;
      ALU_ADD:  r = a + b;
      ALU_SUB:  r = a - b;
      default:  r = b;
    endcase
    return r;
  endfunction

  assign res = alu_eval(op, x, y);

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  opc_t   opcode,
  input  logic   acc_neg,
  input  logic   acc_zero,
  output ctl_t   ctl,
  output phase_e phase,
  output logic   halted
);

  phase_e phase_q, phase_d;

  function automatic logic jump_taken(input opc_t opc, input logic neg, input logic zero);
    logic t;
    case (opc)
      OPC_JUMP: t = 1'b1;
      OPC_JPOS: t = !neg;
      OPC_JNZ:  t = !zero;
      default:  t = 1'b0;
    endcase
    return t;
  endfunction

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_INC;
    phase_d    = phase_q;
    case (phase_q)
      PH_FETCH: begin
        ctl.pc_en = 1'b1;
        ctl.ir_en = 1'b1;
        phase_d   = PH_EXEC;
      end
      PH_EXEC: begin
        ctl.addr_from_ir = 1'b1;
        phase_d          = PH_FETCH;
        case (opcode)
          OPC_LOAD: begin
            ctl.acc_en = 1'b1;
            ctl.alu_op = ALU_PASS;
          end
          OPC_STORE: ctl.mem_we = 1'b1;
          OPC_ADD, OPC_SUB: begin
            ctl.acc_en     = 1'b1;
            ctl.x_from_acc = 1'b1;
            ctl.alu_op     = (opcode == OPC_ADD) ? ALU_ADD : ALU_SUB;
          end
          OPC_JUMP, OPC_JPOS, OPC_JNZ: begin
            ctl.y_from_ir = 1'b1;
            ctl.alu_op    = ALU_PASS;
            ctl.pc_en     = jump_taken(opcode, acc_neg, acc_zero);
          end
          OPC_STOP: phase_d = PH_HALT;
          default: ;
        endcase
      end
      default: phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_FETCH;
    else     phase_q <= phase_d;
  end

  assign phase  = phase_q;
  assign halted = (phase_q == PH_HALT);

  p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

  p_stop_halts_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC && opcode == OPC_STOP) |=> halted);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halted
);

  localparam int unsigned PAD_W = DW - AW;

  ctl_t          ctl;
  phase_e        phase;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, acc;
  logic [DW-1:0] x_bus, y_bus, alu_res;
  logic [AW-1:0] operand;
  opc_t          opcode;

  assign operand = ir[AW-1:0];
  assign opcode  = ir[DW-1:AW];

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .acc_neg  (acc[DW-1]),
    .acc_zero (acc == '0),
    .ctl      (ctl),
    .phase    (phase),
    .halted   (halted)
  );

  assign x_bus = ctl.x_from_acc ? acc : {{PAD_W{1'b0}}, pc};
  assign y_bus = ctl.y_from_ir  ? {{PAD_W{1'b0}}, operand} : mem_rdata;

  acc_alu #(.DW(DW)) u_alu (
    .op  (ctl.alu_op),
    .x   (x_bus),
    .y   (y_bus),
    .res (alu_res)
  );

  acc_enreg #(.W(AW)) u_pc (
    .clk (clk), .rst (rst), .en (ctl.pc_en), .d (alu_res[AW-1:0]), .q (pc)
  );
  acc_enreg #(.W(DW)) u_ir (
    .clk (clk), .rst (rst), .en (ctl.ir_en), .d (mem_rdata), .q (ir)
  );
  acc_enreg #(.W(DW)) u_acc (
    .clk (clk), .rst (rst), .en (ctl.acc_en), .d (alu_res), .q (acc)
  );

  assign mem_addr  = ctl.addr_from_ir ? operand : pc;
  assign mem_wdata = acc;
  assign mem_we    = ctl.mem_we;

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (pc == $past(pc) + AW'(1)));

  p_load_acc_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && opcode == OPC_LOAD) |=> (acc == $past(mem_rdata)));

  p_store_slot_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (phase == PH_EXEC && mem_addr == operand));

  p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && ctl.pc_en) |=> (pc == $past(operand)));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  p_halt_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (halted && $past(halted)) |-> $stable(mem_addr));

endmodule

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted;

  logic [15:0] mem    [4096];
  logic [15:0] shadow [4096];

  typedef struct {
    logic [11:0] addr;
    logic        we;
    logic [15:0] wd;
    logic        hlt;
    string       req;
  } item_t;

  item_t exp_q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    live   = 1'b0;
  bit    ended  = 1'b0;

  always #2.5 clk = ~clk;

  acc_core i_acc_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  // behavioural memory acting on the falling edge
  always @(negedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: one expected bus item per cycle
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (live && exp_q.size() > 0) begin
        it = exp_q.pop_front();
        n_vec++;
        if (mem_addr !== it.addr || mem_we !== it.we || halted !== it.hlt ||
            (it.we && mem_wdata !== it.wd)) begin
          n_fail++;
          $display("FAIL %s: actual addr=%h we=%b wd=%h halt=%b expected addr=%h we=%b wd=%h halt=%b",
                   it.req, mem_addr, mem_we, mem_wdata, halted, it.addr, it.we, it.wd, it.hlt);
        end
      end
    end
  end

  task automatic push(input logic [11:0] a, input logic w, input logic [15:0] d,
                      input logic h, input string r);
    item_t it;
    it.addr = a; it.we = w; it.wd = d; it.hlt = h; it.req = r;
    exp_q.push_back(it);
  endtask

  // reference interpreter written from the requirements
  task automatic expect_program();
    logic [11:0] pc = 12'h000;
    logic [15:0] acc = 16'h0000;
    bit          stop = 1'b0;
    for (int i = 0; i < 4096; i++) shadow[i] = mem[i];
    for (int step = 0; step < 3000 && !stop; step++) begin
      logic [15:0] w;
      logic [3:0]  op;
      logic [11:0] opd;
      logic [11:0] nxt;
      string       r;
      w   = shadow[pc];
      op  = w[15:12];
      opd = w[11:0];
      nxt = pc + 12'd1;
      push(pc, 1'b0, 16'h0, 1'b0, (step > 0 && pc == 12'h000) ? "R11" : "R2");
      case (op)
        4'd0: begin acc = shadow[opd]; r = "R3"; end
        4'd1: begin shadow[opd] = acc; r = "R3"; end
        4'd2: begin acc = acc + shadow[opd]; r = "R4"; end
        4'd3: begin acc = acc - shadow[opd]; r = "R5"; end
        4'd4: begin nxt = opd; r = "R6"; end
        4'd5: begin if (!acc[15]) nxt = opd; r = "R7"; end
        4'd6: begin if (acc != 16'h0) nxt = opd; r = "R8"; end
        4'd7: begin stop = 1'b1; r = "R9"; end
        default: r = "R10";
      endcase
      push(opd, (op == 4'd1), acc, 1'b0, r);
      pc = nxt;
    end
    for (int k = 0; k < 4; k++) push(pc, 1'b0, 16'h0, 1'b1, "R9");
  endtask

  task automatic reset_and_check();
    @(negedge clk);
    rst  = 1'b1;
    live = 1'b0;
    @(negedge clk);
    #1;
    check("R1 addr", {4'h0, mem_addr}, 16'h0000);
    check("R1 we",   {15'h0, mem_we},  16'h0000);
    check("R1 halt", {15'h0, halted},  16'h0000);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run();
    expect_program();
    @(negedge clk);
    rst  = 1'b0;
    live = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    #2;
    live = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    // R12: worked example, then the same code with random operands
    reset_and_check();
    clear_mem();
    mem[0] = 16'h0004; mem[1] = 16'h2005; mem[2] = 16'h1006; mem[3] = 16'h7000;
    mem[4] = 16'h000A; mem[5] = 16'h0001; mem[6] = 16'h0000;
    run();
    check("R12 result", mem[6], 16'h000B);

    for (int t = 0; t < 3; t++) begin
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = 16'($urandom);
      reset_and_check();
      mem[4] = a; mem[5] = b; mem[6] = 16'h0000;
      run();
      check("R4 random sum", mem[6], a + b);
    end

    // counting loop: R3 R5 R8
    reset_and_check();
    clear_mem();
    mem[0] = 16'h0030; mem[1] = 16'h2031; mem[2] = 16'h1030; mem[3] = 16'h0031;
    mem[4] = 16'h3032; mem[5] = 16'h1031; mem[6] = 16'h6000; mem[7] = 16'h7000;
    mem[12'h30] = 16'h0000; mem[12'h31] = 16'h0005; mem[12'h32] = 16'h0001;
    run();
    check("R8 loop sum", mem[12'h30], 16'h000F);

    // sign tests, wrap arithmetic, no-ops, jumps: R5 R7 R8 R10 R6
    reset_and_check();
    clear_mem();
    mem[0]  = 16'h0020; mem[1]  = 16'h3021; mem[2]  = 16'h1022; mem[3]  = 16'h5006;
    mem[4]  = 16'h8123; mem[5]  = 16'hF000; mem[6]  = 16'h2023; mem[7]  = 16'h1024;
    mem[8]  = 16'h500A; mem[9]  = 16'h7000; mem[10] = 16'h2025; mem[11] = 16'h600D;
    mem[12] = 16'h1026; mem[13] = 16'h4010; mem[16] = 16'h1027; mem[17] = 16'h7000;
    mem[12'h20] = 16'h0003; mem[12'h21] = 16'h0005; mem[12'h23] = 16'h7FFF;
    mem[12'h25] = 16'h8003; mem[12'h26] = 16'h5555;
    run();
    check("R5 underflow",   mem[12'h22], 16'hFFFE);
    check("R10 nop keeps",  mem[12'h24], 16'h7FFD);
    check("R8 zero result", mem[12'h26], 16'h0000);

    // PC wrap and taken JGE: R11 R7
    reset_and_check();
    clear_mem();
    mem[0] = 16'h0010; mem[1] = 16'h6004; mem[2] = 16'h2011; mem[3] = 16'h5FFE;
    mem[4] = 16'h7000;
    mem[12'hFFE] = 16'h1010; mem[12'hFFF] = 16'h9000;
    mem[12'h10] = 16'h0000; mem[12'h11] = 16'h0001;
    run();
    check("R11 flag", mem[12'h10], 16'h0001);

    // R1: reset out of the halted state
    reset_and_check();
    report();
  end

endmodule